// File: doc/BRIEF.md
# Time-Multiplexed Multichannel FIR Filter

This block runs one systolic FIR datapath for several channels at once. Samples from all channels arrive interleaved on a single stream, one per clock, in a fixed round-robin slot order. Because every storage element in the cascade is one channel period deep, the same multiply-add chain works on each channel's own history in turn. With eight channels, the chain replaces eight separate filters at about an eighth of the logic cost. The clock must run at least `NUM_CH` times the per-channel sample rate, and an elaboration check rejects parameter sets that break this.

Each tap multiplies the sample that reaches it by a fixed coefficient and adds the partial sum handed up from the previous tap. The sample stream and the partial-sum stream each have their own tap-to-tap cascade. Both operands are sign-extended before use, and the result comes out at full precision, with enough growth bits that no sum can wrap. The channel index and the valid strobe travel through a delay line that matches the datapath depth, so every result leaves tagged with its channel.

Top module: `tdm_fir`

## Requirements
- R1: For every channel c, a valid output equals sum over k of `COEFS[k] * x_c[n-k]` exactly, where `x_c[n]` is that channel's n-th slot sample and `COEFS[0]` applies to the newest sample.
- R2: A slot captured on clock edge e produces its result right after edge e+TAPS+1 (TAPS+2 register stages). At that point `out_valid` equals the slot's `in_valid` and `out_ch` equals its `in_ch`.
- R3: A channel's output depends only on that channel's own samples. An impulse on one channel leaves every other channel's output at zero.
- R4: A slot with `in_valid` low enters its channel's history as a zero sample, whatever value `in_data` holds.
- R5: Synchronous reset clears all history. On the first edge with `rst` low after a reset, `out_valid` is 0 and `out_data` is 0, and later results depend only on samples given after the reset.
- R6: The accumulator is `DATA_W+COEF_W+clog2(TAPS)` bits wide, so even most-negative samples times most-negative coefficients on every tap come out exact and do not wrap.
- R7: Channel c must occupy every slot congruent to c modulo `NUM_CH`. Consecutive valid inputs carry channel indices that increase by one modulo `NUM_CH`, and so do consecutive valid outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one channel slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slot carries a real sample |
| in_ch | input | CH_W | Channel index of the slot |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result corresponds to a valid input slot |
| out_ch | output | CH_W | Channel index of the result |
| out_data | output | ACC_W | Signed full-precision filter result |

## Verification
The hardest situation to reach is history crossing between channels or surviving a reset. Both stay invisible while every channel carries similar data. The stimulus therefore puts a lone impulse on one channel among silent neighbours, thins a random stream with idle slots that hold garbage data, and asserts reset while results are still in flight before starting a second impulse. A per-channel reference convolution checks every result slot, and separate checks cover the all-extreme operand case that exercises the growth bits.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

    // Accumulator width: full product plus growth bits for the tap count.
    function automatic int acc_width(input int dw, input int cw, input int taps);
        return dw + cw + ((taps > 1) ? $clog2(taps) : 0);
    endfunction

    // Register stages from input to output: front register, product, and
    // one accumulator per tap.
    function automatic int pipe_latency(input int taps);
        return taps + 2;
    endfunction

    function automatic int ch_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int next_ch(input int c, input int n);
        return (c + 1) % n;
    endfunction

endpackage

// File: rtl/tdm_fir_delay.sv
// Generic shift line used both for the per-tap sample cascade and for the
// channel/valid tag pipeline.
module tdm_fir_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } line_s;

    line_s line_d, line_q;

    always_comb begin
        line_d        = line_q;
        line_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            line_d.stg[i] = line_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign dout = line_q.stg[DEPTH-1];

endmodule

// File: rtl/tdm_fir_tap.sv
// One tap: registered multiply, then registered add of the incoming partial sum.
module tdm_fir_tap #(
    parameter int                    DW   = 16,
    parameter int                    CW   = 16,
    parameter int                    AW   = 34,
    parameter int                    IDX  = 0,
    parameter logic signed [CW-1:0]  COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [AW-1:0] psum_in,
    output logic signed [AW-1:0] psum_out
);

    localparam int PW = DW + CW;

    typedef struct packed {
        logic [PW-1:0] prod;
        logic [AW-1:0] acc;
    } tap_s;

    tap_s tap_d, tap_q;

    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] c_ext;
    logic signed [PW-1:0] prod_s;
    logic signed [AW-1:0] prod_ext;

    always_comb begin
        x_ext        = x_in;                 // sign extension of the sample
        c_ext        = COEF;                 // sign extension of the coefficient
        prod_s       = $signed(tap_q.prod);
        prod_ext     = prod_s;               // sign extension to accumulator width
        tap_d        = tap_q;
        tap_d.prod   = x_ext * c_ext;
        tap_d.acc    = prod_ext + psum_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end

    assign psum_out = $signed(tap_q.acc);

    // The partial sum after tap IDX holds IDX+1 products, each no larger in
    // magnitude than 2^(PW-2).
    localparam logic [AW+1:0] LIM = (AW+2)'(IDX + 1) << (PW - 2);
    logic [AW+1:0] acc_wide;
    assign acc_wide = {{2{tap_q.acc[AW-1]}}, tap_q.acc};

    assert_acc_bound_R6: assert property (@(posedge clk) disable iff (rst)
        ($signed(acc_wide) <= $signed(LIM)) && ($signed(acc_wide) >= -$signed(LIM)))
        else $error("partial sum of tap %0d outside product bound", IDX);

endmodule

// File: rtl/tdm_fir.sv
module tdm_fir import tdm_fir_pkg::*; #(
    parameter int NUM_CH      = 8,
    parameter int TAPS        = 4,
    parameter int DATA_W      = 16,
    parameter int COEF_W      = 16,
    parameter logic signed [COEF_W-1:0] COEFS [TAPS] =
        '{16'sh8000, 16'sd12345, -16'sd7, 16'sd32767},
    parameter int CH_RATE_KHZ = 62500,
    parameter int FMAX_KHZ    = 500000,
    localparam int CH_W       = ch_width(NUM_CH),
    localparam int ACC_W      = acc_width(DATA_W, COEF_W, TAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_ch,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic [CH_W-1:0]          out_ch,
    output logic signed [ACC_W-1:0]  out_data
);

    localparam int LAT     = pipe_latency(TAPS);
    localparam int X_DEPTH = NUM_CH + 1;  // one channel period plus alignment stage
    localparam int TAG_W   = CH_W + 1;

    // Elaboration-time rate check: all channels must fit into one clock.
    if (NUM_CH * CH_RATE_KHZ > FMAX_KHZ) begin : g_rate_bad
        $error("channel count times channel rate exceeds datapath clock");
    end

    // Front register: idle slots enter the chain as zero.
    typedef struct packed {
        logic [DATA_W-1:0] smp;
    } front_s;

    front_s front_d, front_q;

    always_comb begin
        front_d     = front_q;
        front_d.smp = in_valid ? in_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

    logic signed [DATA_W-1:0] xs [TAPS];
    logic signed [ACC_W-1:0]  ps [TAPS];

    assign xs[0] = $signed(front_q.smp);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_first
            tdm_fir_tap #(
                .DW(DATA_W), .CW(COEF_W), .AW(ACC_W), .IDX(k), .COEF(COEFS[k])
            ) tap_i (
                .clk(clk), .rst(rst), .x_in(xs[k]),
                .psum_in('0), .psum_out(ps[k])
            );
        end else begin : g_rest
            tdm_fir_tap #(
                .DW(DATA_W), .CW(COEF_W), .AW(ACC_W), .IDX(k), .COEF(COEFS[k])
            ) tap_i (
                .clk(clk), .rst(rst), .x_in(xs[k]),
                .psum_in(ps[k-1]), .psum_out(ps[k])
            );
        end
        if (k < TAPS - 1) begin : g_xcas
            tdm_fir_delay #(.W(DATA_W), .DEPTH(X_DEPTH)) xdly_i (
                .clk(clk), .rst(rst), .din(xs[k]), .dout(xs[k+1])
            );
        end
    end

    logic [TAG_W-1:0] tag_in, tag_out;
    assign tag_in = {in_valid, in_ch};

    tdm_fir_delay #(.W(TAG_W), .DEPTH(LAT)) tag_i (
        .clk(clk), .rst(rst), .din(tag_in), .dout(tag_out)
    );

    assign out_valid = tag_out[CH_W];
    assign out_ch    = tag_out[CH_W-1:0];
    assign out_data  = ps[TAPS-1];

    // ---------------- assertions ----------------
    assert_rst_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_data == '0))
        else $error("outputs not cleared by reset");

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (xs[0] == '0))
        else $error("idle slot entered chain with nonzero sample");

    assert_in_order_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(in_valid)) |->
            (int'(in_ch) == next_ch(int'($past(in_ch)), NUM_CH)))
        else $error("input channel order broken");

    assert_out_order_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |->
            (int'(out_ch) == next_ch(int'($past(out_ch)), NUM_CH)))
        else $error("output channel order broken");

endmodule

// File: tb/tdm_fir_tb_top.sv
module tdm_fir_tb_top;

    localparam int NCH  = 8;
    localparam int TAPS = 4;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int CHW  = 3;
    localparam int AW   = DW + CW + 2;
    localparam int LAT  = TAPS + 2;   // R2
    localparam logic signed [CW-1:0] TB_COEFS [TAPS] =
        '{16'sh8000, 16'sd12345, -16'sd7, 16'sd32767};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [CHW-1:0]       in_ch = '0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic [CHW-1:0]       out_ch;
    logic signed [AW-1:0] out_data;

    always #10 clk = ~clk;

    tdm_fir #(
        .NUM_CH(NCH), .TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .COEFS(TB_COEFS)
    ) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
        .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
    );

    typedef struct {
        int     due;
        bit     vld;
        int     ch;
        longint val;
        string  tag;
    } exp_t;

    exp_t   expq[$];
    longint hist [NCH][TAPS];
    int     cyc = 0;
    int     slot = 0;
    int     n_checks = 0;
    int     n_fail = 0;
    bit     prev_ov = 0;
    int     prev_och = 0;
    bit     finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic clear_model();
        expq.delete();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < TAPS; k++)
                hist[c][k] = 0;
        slot = 0;
        prev_ov = 0;
    endtask

    task automatic check_outputs();
        longint got;
        got = out_data;
        if (expq.size() > 0 && expq[0].due == cyc) begin
            exp_t e;
            e = expq.pop_front();
            chk(out_valid == e.vld, "R2", {e.tag, " out_valid"}, out_valid, e.vld);
            if (e.vld) begin
                chk(int'(out_ch) == e.ch, "R2", {e.tag, " out_ch"}, out_ch, e.ch);
                chk(got == e.val, e.tag, "out_data (R1 reference)", got, e.val);
            end
        end else begin
            // Only the flush window right after reset has nothing due: R5.
            chk(!out_valid, "R5", "out_valid in flush window", out_valid, 0);
            chk(got == 0, "R5", "out_data in flush window", got, 0);
        end
        if (out_valid && prev_ov)
            chk(int'(out_ch) == (prev_och + 1) % NCH, "R7", "output channel order",
                out_ch, (prev_och + 1) % NCH);
        prev_ov  = out_valid;
        prev_och = out_ch;
    endtask

    // Called at a falling edge: check outputs, drive one slot, advance one clock.
    task automatic tick(input bit v, input logic signed [DW-1:0] d, input string tag);
        exp_t   e;
        longint s;
        check_outputs();
        in_valid = v;
        in_ch    = CHW'(slot);
        in_data  = d;
        s = v ? longint'(d) : 0;   // R4: idle slot is a zero sample
        for (int k = TAPS - 1; k > 0; k--) hist[slot][k] = hist[slot][k-1];
        hist[slot][0] = s;
        e.val = 0;
        for (int k = 0; k < TAPS; k++) e.val += longint'(TB_COEFS[k]) * hist[slot][k];
        e.due = cyc + LAT;
        e.vld = v;
        e.ch  = slot;
        e.tag = tag;
        expq.push_back(e);
        slot = (slot + 1) % NCH;
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        clear_model();
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        chk(!out_valid, "R5", "out_valid during reset", out_valid, 0);
        chk(out_data == 0, "R5", "out_data during reset", out_data, 0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(3);

        // R3: impulse on channel 2, all other channels silent.
        for (int i = 0; i < NCH * (TAPS + 2); i++)
            tick(1'b1, (i == 2) ? 16'sd1000 : 16'sd0, "R3");

        // R1: random full-scale stream on every channel.
        for (int i = 0; i < 400; i++)
            tick(1'b1, DW'($urandom), "R1");

        // R4: idle slots carry garbage data that must be ignored.
        for (int i = 0; i < 400; i++) begin
            bit v;
            v = ($urandom % 10) >= 3;
            tick(v, DW'($urandom), "R4");
        end

        // R6: extreme operands, most negative and most positive samples.
        for (int i = 0; i < 6 * NCH; i++)
            tick(1'b1, 16'sh8000, "R6");
        for (int i = 0; i < 6 * NCH; i++)
            tick(1'b1, ((i / NCH) % 2 == 0) ? 16'sh7fff : 16'sh8000, "R6");

        // R5: reset while results are in flight, then a fresh impulse on channel 5.
        for (int i = 0; i < 50; i++)
            tick(1'b1, DW'($urandom), "R1");
        do_reset(2);
        for (int i = 0; i < NCH * (TAPS + 2); i++)
            tick(1'b1, (i == 5) ? -16'sd3 : 16'sd0, "R5");
        for (int i = 0; i < 200; i++)
            tick(1'b1, DW'($urandom), "R1");

        // Drain the pipeline.
        for (int i = 0; i < LAT + 2; i++)
            tick(1'b0, 16'sd0, "R2");

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule